// File: doc/BRIEF.md
# Serial Control Register Interface

A three-wire configuration port for an image-sensor timing generator. A host shifts a 32-bit control word in on a data pin, one bit per rising edge of a shift clock, then raises a strobe to commit the word. All three pins are asynchronous to the block's system clock. Each pin passes through a two-flop synchroniser before use, and the shift clock and strobe are then edge-detected.

The word goes through two update stages. Bit 12 is the power-save bit, and it takes effect in the same cycle the strobe is seen. Every other bit goes first into a shadow register. It reaches the active configuration output only when the timing logic pulses `line_apply_i` to mark the line that carries the readout pulses. A strobe with bit 12 set clears the shadow and active fields but keeps the power-save flag, and it leaves the shift register as it is. An active-low asynchronous clear zeroes every register.

A control state machine sequences the commits and has three states. `ST_IDLE` means the active fields equal the shadow. `ST_PENDING` means the shadow holds a word that has not yet been applied. `ST_SAVE` means power-save is on. Transitions: any state goes to `ST_SAVE` on a strobe with bit 12 = 1. Any state goes to `ST_PENDING` on a strobe with bit 12 = 0. `ST_PENDING` goes to `ST_IDLE` on an apply pulse with no strobe in the same cycle. The asynchronous clear returns the machine to `ST_IDLE`.

Top module: `serial_cfg_port`

## Requirements
- R1: While `clr_n` is low, `cfg_o` and `psave_o` are 0 at once (asynchronous), and the shift register is cleared. A strobe issued after the clear with no bits shifted commits an all-zero word.
- R2: Each synchronised rising edge of `sclk_i` shifts in one bit from `sdat_i`. The first bit received becomes word bit 0 (D00) and the 32nd becomes bit 31.
- R3: A strobe with bit 12 = 0 loads the word into the shadow only. `cfg_o` bits other than 12 do not change until an apply pulse arrives.
- R4: When `line_apply_i` is high at a clock edge, `cfg_o` shows the shadow word (bit 12 excluded) from that edge on.
- R5: Bit 12 of a committed word drives `psave_o`, and `cfg_o[12]` mirrors it. The flag changes at the strobe without any apply pulse.
- R6: A strobe with bit 12 = 1 clears the shadow and active fields at once, so `cfg_o` equals 32'h0000_1000. The shift register contents are kept, so a second strobe with no new bits sets power-save again.
- R7: While power-save is on, `line_apply_i` has no effect. A later strobe with bit 12 = 0 clears `psave_o` and loads the shadow, and the next apply pulse makes that word active.
- R8: If more than 32 bits arrive before a strobe, only the last 32 received are committed, and the oldest of them is bit 0.
- R9: If a strobe and an apply pulse land in the same clock cycle, the active fields take the shadow value from before that strobe, and the shadow takes the new word.
- R10: With the default two synchroniser stages, a strobe rising before clock edge P0 changes the outputs at edge P0+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous active-low all-clear |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdat_i | input | 1 | Serial data (asynchronous) |
| sstb_i | input | 1 | Commit strobe (asynchronous, rising edge) |
| line_apply_i | input | 1 | Pulse from the timing logic marking the readout line |
| cfg_o | output | 32 | Active configuration word; bit 12 mirrors power-save |
| psave_o | output | 1 | Power-save flag |

## Verification
Two functions can fall in the same cycle: a strobe commit and an apply copy. The bench provokes this by raising `line_apply_i` in exactly the cycle in which the synchronised strobe edge reaches the control logic. It first leaves a different word pending, so the old shadow and the new word can be told apart. The result is judged when `cfg_o` shows the previously pending word, and only after a second apply does it show the new one. Power-save strobes meeting apply pulses, and an apply pulse during power-save, are judged the same way against the behavioural model on every clock.

// File: rtl/scp_pkg.sv
package scp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PENDING = 2'd1,
        ST_SAVE    = 2'd2
    } scp_state_e;
endpackage

// File: rtl/scp_sync.sv
// Multi-stage synchroniser for one asynchronous level.
module scp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scp_shifter.sv
// Receive shift register: newest bit enters at the top, so the first of
// the last W bits ends up in bit 0.
module scp_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)        word <= '0;
        else if (shift_en) word <= {din, word[W-1:1]};
    end
endmodule

// File: rtl/scp_ctrl.sv
// Commit sequencer: decides when the shadow loads, when the active
// fields copy, and when power-save clears everything else.
module scp_ctrl
    import scp_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  logic       stb_evt,
    input  logic       ps_bit,
    input  logic       apply,
    output logic       set_ps,
    output logic       clr_ps,
    output logic       ld_shd,
    output logic       cp_act,
    output logic       clr_fields,
    output scp_state_e state_o
);
    scp_state_e state, state_nx;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx   = state;
        set_ps     = 1'b0;
        clr_ps     = 1'b0;
        ld_shd     = 1'b0;
        cp_act     = 1'b0;
        clr_fields = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (stb_evt && ps_bit) begin
                    set_ps     = 1'b1;
                    clr_fields = 1'b1;
                    state_nx   = ST_SAVE;
                end else if (stb_evt) begin
                    clr_ps   = 1'b1;
                    ld_shd   = 1'b1;
                    state_nx = ST_PENDING;
                end
            end
            ST_PENDING: begin
                if (stb_evt && ps_bit) begin
                    set_ps     = 1'b1;
                    clr_fields = 1'b1;
                    state_nx   = ST_SAVE;
                end else if (stb_evt) begin
                    clr_ps   = 1'b1;
                    ld_shd   = 1'b1;
                    cp_act   = apply;
                    state_nx = ST_PENDING;
                end else if (apply) begin
                    cp_act   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_SAVE: begin
                if (stb_evt && ps_bit) begin
                    set_ps     = 1'b1;
                    clr_fields = 1'b1;
                end else if (stb_evt) begin
                    clr_ps   = 1'b1;
                    ld_shd   = 1'b1;
                    state_nx = ST_PENDING;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign state_o = state;
endmodule

// File: rtl/scp_regs.sv
// Power-save flag, shadow word and active word.
module scp_regs #(
    parameter int W      = 32,
    parameter int PS_BIT = 12
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         set_ps,
    input  logic         clr_ps,
    input  logic         ld_shd,
    input  logic         cp_act,
    input  logic         clr_fields,
    input  logic [W-1:0] word,
    output logic         psave,
    output logic [W-1:0] active
);
    localparam logic [W-1:0] PS_MASK = W'(1) << PS_BIT;

    logic [W-1:0] shadow;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      psave <= 1'b0;
        else if (set_ps) psave <= 1'b1;
        else if (clr_ps) psave <= 1'b0;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)          shadow <= '0;
        else if (clr_fields) shadow <= '0;
        else if (ld_shd)     shadow <= word & ~PS_MASK;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)          active <= '0;
        else if (clr_fields) active <= '0;
        else if (cp_act)     active <= shadow;
    end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
    parameter int WORD_W      = 32,
    parameter int PS_BIT      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              sclk_i,
    input  logic              sdat_i,
    input  logic              sstb_i,
    input  logic              line_apply_i,
    output logic [WORD_W-1:0] cfg_o,
    output logic              psave_o
);
    import scp_pkg::*;

    localparam logic [WORD_W-1:0] PS_MASK = WORD_W'(1) << PS_BIT;

    logic sclk_s, sdat_s, sstb_s;
    logic sclk_d, sstb_d;
    logic sclk_evt, stb_evt;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] active;
    logic set_ps, clr_ps, ld_shd, cp_act, clr_fields;
    scp_state_e state;

    scp_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
        .clk(clk), .clr_n(clr_n), .d(sclk_i), .q(sclk_s));
    scp_sync #(.STAGES(SYNC_STAGES)) u_sync_sdat (
        .clk(clk), .clr_n(clr_n), .d(sdat_i), .q(sdat_s));
    scp_sync #(.STAGES(SYNC_STAGES)) u_sync_sstb (
        .clk(clk), .clr_n(clr_n), .d(sstb_i), .q(sstb_s));

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            sclk_d <= 1'b0;
            sstb_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sstb_d <= sstb_s;
        end
    end

    assign sclk_evt = sclk_s & ~sclk_d;
    assign stb_evt  = sstb_s & ~sstb_d;

    scp_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .clr_n(clr_n), .shift_en(sclk_evt), .din(sdat_s),
        .word(shreg));

    scp_ctrl u_ctrl (
        .clk(clk), .clr_n(clr_n), .stb_evt(stb_evt), .ps_bit(shreg[PS_BIT]),
        .apply(line_apply_i), .set_ps(set_ps), .clr_ps(clr_ps),
        .ld_shd(ld_shd), .cp_act(cp_act), .clr_fields(clr_fields),
        .state_o(state));

    scp_regs #(.W(WORD_W), .PS_BIT(PS_BIT)) u_regs (
        .clk(clk), .clr_n(clr_n), .set_ps(set_ps), .clr_ps(clr_ps),
        .ld_shd(ld_shd), .cp_act(cp_act), .clr_fields(clr_fields),
        .word(shreg), .psave(psave_o), .active(active));

    assign cfg_o = (active & ~PS_MASK) | ({WORD_W{psave_o}} & PS_MASK);
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
    parameter int WORD_W = 32,
    parameter int PS_BIT = 12
) (
    input logic              clk,
    input logic              clr_n,
    input logic              line_apply_i,
    input logic [WORD_W-1:0] cfg_o,
    input logic              psave_o,
    input logic              stb_evt,
    input logic              sclk_evt,
    input logic [WORD_W-1:0] shreg,
    input logic [1:0]        state
);
    localparam logic [WORD_W-1:0] PS_MASK = WORD_W'(1) << PS_BIT;

    p_fields_zero_in_save_r6: assert property (@(posedge clk) disable iff (!clr_n)
        psave_o |-> ((cfg_o & ~PS_MASK) == '0));

    p_fields_move_on_apply_r4: assert property (@(posedge clk) disable iff (!clr_n)
        !$stable(cfg_o & ~PS_MASK) |-> ($past(line_apply_i) || psave_o));

    p_psave_on_strobe_r5: assert property (@(posedge clk) disable iff (!clr_n)
        !$stable(psave_o) |-> $past(stb_evt));

    p_shift_on_edge_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !$stable(shreg) |-> $past(sclk_evt));

    p_save_state_r7: assert property (@(posedge clk) disable iff (!clr_n)
        psave_o == (state == 2'd2));
endmodule

bind serial_cfg_port scp_checker #(.WORD_W(WORD_W), .PS_BIT(PS_BIT)) u_chk (
    .clk(clk), .clr_n(clr_n), .line_apply_i(line_apply_i), .cfg_o(cfg_o),
    .psave_o(psave_o), .stb_evt(stb_evt), .sclk_evt(sclk_evt),
    .shreg(shreg), .state(state));

// File: tb/serial_cfg_port_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_port_tb_top;
    logic clk = 1'b0;
    logic clr_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sstb = 1'b0, apply = 1'b0;
    logic [31:0] cfg;
    logic psave;

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    bit q[$];
    logic [31:0] shd_e = '0, act_e = '0;
    logic ps_e = 1'b0;

    always #5 clk = ~clk;

    serial_cfg_port dut_i (
        .clk(clk), .clr_n(clr_n), .sclk_i(sclk), .sdat_i(sdat), .sstb_i(sstb),
        .line_apply_i(apply), .cfg_o(cfg), .psave_o(psave));

    function automatic logic [31:0] exp_cfg();
        return act_e | (32'(ps_e) << 12);
    endfunction

    function automatic logic [31:0] last_word();
        logic [31:0] w;
        for (int i = 0; i < 32; i++) w[i] = q[q.size() - 32 + i];
        return w;
    endfunction

    task automatic model_clear();
        q.delete();
        for (int i = 0; i < 32; i++) q.push_back(1'b0);
        shd_e = '0; act_e = '0; ps_e = 1'b0;
    endtask

    task automatic model_apply();
        if (!ps_e) act_e = shd_e;
    endtask

    task automatic model_strobe();
        logic [31:0] w;
        w = last_word();
        if (w[12]) begin
            ps_e = 1'b1; shd_e = '0; act_e = '0;
        end else begin
            ps_e = 1'b0; shd_e = w; shd_e[12] = 1'b0;
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (clr_n) begin
            vectors++;
            if (cfg !== exp_cfg() || psave !== ps_e) begin
                fails++;
                $display("FAIL %s cycle compare: cfg=%h ps=%b expected cfg=%h ps=%b",
                         cur_req, cfg, psave, exp_cfg(), ps_e);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk); sdat = b; sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
        q.push_back(b);
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 0; i < 32; i++) send_bit(w[i]);
    endtask

    task automatic strobe(input bit with_apply);
        @(negedge clk); sstb = 1'b1;
        @(posedge clk);
        @(posedge clk);
        if (with_apply) begin @(negedge clk); apply = 1'b1; end
        @(posedge clk);
        #1;
        if (with_apply) model_apply();
        model_strobe();
        @(negedge clk); apply = 1'b0; sstb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_apply();
        @(negedge clk); apply = 1'b1;
        @(posedge clk); #1; model_apply();
        @(negedge clk); apply = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        check("R1 reset cfg", cfg, 32'h0);
        check("R1 reset psave", 32'(psave), 32'h0);
        clr_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R3";
        send_word(32'hA5C3_0F96);
        strobe(1'b0);
        check("R3 shadow not visible", cfg, 32'h0);

        cur_req = "R4";
        pulse_apply();
        check("R2 R4 applied word", cfg, 32'hA5C3_0F96);

        cur_req = "R8";
        send_word(32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_word(32'h1234_0ABC);
        strobe(1'b0);
        pulse_apply();
        check("R8 last 32 bits", cfg, 32'h1234_0ABC);

        cur_req = "R9";
        send_word(32'h0F0F_8001);
        strobe(1'b0);
        check("R9 pending kept back", cfg, 32'h1234_0ABC);
        send_word(32'h3C3C_0303);
        strobe(1'b1);
        check("R9 same-cycle takes old shadow", cfg, 32'h0F0F_8001);
        pulse_apply();
        check("R9 new word after apply", cfg, 32'h3C3C_0303);

        cur_req = "R10";
        send_word(32'hDEAD_1EEF);
        @(negedge clk); sstb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R10 no change after P0", 32'(psave), 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R10 no change after P1", 32'(psave), 32'h0);
        @(posedge clk); #1; model_strobe();
        @(negedge clk); sstb = 1'b0;
        check("R5 psave set at strobe", 32'(psave), 32'h1);
        check("R6 fields cleared", cfg, 32'h0000_1000);
        repeat (3) @(negedge clk);

        cur_req = "R6";
        strobe(1'b0);
        check("R6 shift reg kept, psave again", 32'(psave), 32'h1);

        cur_req = "R7";
        pulse_apply();
        check("R7 apply ignored in save", cfg, 32'h0000_1000);
        send_word(32'h0000_0005);
        strobe(1'b0);
        check("R7 psave released", 32'(psave), 32'h0);
        check("R7 fields still zero", cfg, 32'h0);
        pulse_apply();
        check("R7 word active after release", cfg, 32'h0000_0005);

        cur_req = "R1";
        send_word(32'h7777_0777);
        strobe(1'b0);
        pulse_apply();
        @(negedge clk); clr_n = 1'b0; #1; model_clear();
        check("R1 async clear cfg", cfg, 32'h0);
        check("R1 async clear psave", 32'(psave), 32'h0);
        @(negedge clk); clr_n = 1'b1;
        repeat (2) @(negedge clk);
        strobe(1'b0);
        pulse_apply();
        check("R1 shift reg cleared", cfg, 32'h0);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule